// File: doc/BRIEF.md
# UART Channel Mode Data Router

This block sits between a UART's host-facing data register, its two byte FIFOs and the line-side receiver. It decides, cycle by cycle, which FIFO (if any) a byte written by the host or a byte delivered by the line receiver is pushed into, and it pops the receive FIFO when the host reads the data register. The routing follows a two-bit channel mode: normal operation, echo (line bytes are both received and sent back), local loopback (host writes come straight back into the receive FIFO) and remote loopback (line bytes are returned to the line without reaching the host).

The block also owns the control and mode registers. The control register carries the per-direction enable and disable bits that gate each path, plus two self-clearing bits that flush the FIFOs. It reports to the line receiver whether every FIFO the current mode would write has room, and it raises a one-cycle overrun pulse whenever a byte on an enabled path is lost because its FIFO is full. The FIFO storage and the bit-level serializer live outside; the block sees only their occupancy counts, the receive write pointer and the receive read data.

Top module: `chm_router`

## Requirements
- R1: The channel mode is taken from bits 9:8 of the mode register (0 normal, 1 echo, 2 local loopback, 3 remote loopback); a mode write stores all 10 bits and `mode_q` shows them from the next cycle; after reset the register is 0.
- R2: A host data write pushes the byte into TX in normal mode and into RX in local loopback; in echo and remote loopback it produces no push.
- R3: A line byte is pushed into RX in normal mode, into TX in remote loopback, into both in echo mode, and into neither in local loopback.
- R4: The RX path (pushes, pops, overrun) acts only while control bit 2 is 1 and control bit 3 is 0; the TX path likewise needs control bit 4 set and bit 5 clear; a byte on a gated path is dropped with no overrun.
- R5: A byte bound for a FIFO whose count equals DEPTH (64) is not pushed, and `rx_overrun` is high for one cycle in the cycle after the drop.
- R6: A host read with the RX path enabled and a nonzero RX count pops RX in the same cycle and returns `rx_rd_data`; otherwise there is no pop and the read returns 0.
- R7: The RX read address equals the RX write pointer minus the RX count, modulo DEPTH.
- R8: `line_ready` is 1 exactly when every FIFO the current mode routes line bytes to has a count below DEPTH (always 1 in local loopback).
- R9: A control write with bit 0 set pulses `rx_flush` and with bit 1 set pulses `tx_flush` in the write cycle; the stored register reads those two bits as 0 and keeps the written bits 8:2.
- R10: After reset the control register reads 0x128 (both paths disabled).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_ctrl_we | input | 1 | Control register write strobe |
| cfg_ctrl_wdata | input | 9 | Control register write data |
| cfg_mode_we | input | 1 | Mode register write strobe |
| cfg_mode_wdata | input | 10 | Mode register write data |
| ctrl_q | output | 9 | Stored control register |
| mode_q | output | 10 | Stored mode register |
| host_wr | input | 1 | Host write of the data register |
| host_wdata | input | 8 | Host write byte |
| host_rd | input | 1 | Host read of the data register |
| host_rdata | output | 8 | Host read byte |
| line_valid | input | 1 | Line receiver delivers a byte |
| line_data | input | 8 | Line byte |
| line_ready | output | 1 | All FIFOs targeted by the mode have room |
| rx_count | input | 7 | RX FIFO occupancy |
| tx_count | input | 7 | TX FIFO occupancy |
| rx_wptr | input | 6 | RX FIFO write pointer |
| rx_rd_data | input | 8 | RX FIFO byte at `rx_rd_addr` |
| rx_rd_addr | output | 6 | RX FIFO read address |
| rx_push | output | 1 | Push strobe into RX |
| rx_push_data | output | 8 | Byte pushed into RX |
| tx_push | output | 1 | Push strobe into TX |
| tx_push_data | output | 8 | Byte pushed into TX |
| rx_pop | output | 1 | Pop strobe from RX |
| rx_flush | output | 1 | RX flush pulse |
| tx_flush | output | 1 | TX flush pulse |
| rx_overrun | output | 1 | One-cycle pulse after a byte was lost to a full FIFO |

## Verification
Push, pop and read-address outputs are combinational from the ports and the two registers, so a wrong route decode or gate shows at the push strobes in the very cycle the byte is offered, and a scoreboard of expected pushes catches both missing and extra ones. A wrong stored control or mode value shows one cycle after its write, through `ctrl_q`, `mode_q` and the routing that follows. The overrun register is the only delayed state; a stuck or missing pulse shows one cycle after the drop, and the bench checks both that cycle and the one after.

// File: rtl/chm_router_pkg.sv
package chm_router_pkg;

   localparam int CTRL_W   = 9;
   localparam int MODE_W   = 10;
   localparam int MODE_LSB = 8;

   localparam int CB_RX_FLUSH = 0;
   localparam int CB_TX_FLUSH = 1;
   localparam int CB_RX_EN    = 2;
   localparam int CB_RX_DIS   = 3;
   localparam int CB_TX_EN    = 4;
   localparam int CB_TX_DIS   = 5;

   localparam logic [CTRL_W-1:0] CTRL_RST = 9'h128;
   localparam logic [MODE_W-1:0] MODE_RST = '0;

   typedef enum logic [1:0] {
      CHM_NORMAL    = 2'd0,
      CHM_ECHO      = 2'd1,
      CHM_LOCAL_LB  = 2'd2,
      CHM_REMOTE_LB = 2'd3
   } chan_mode_e;

   typedef struct packed {
      logic host_rx;
      logic host_tx;
      logic line_rx;
      logic line_tx;
   } route_t;

   localparam int PATH_RX = 0;
   localparam int PATH_TX = 1;
   localparam int NPATH   = 2;

endpackage

// File: rtl/chm_cfg_regs.sv
module chm_cfg_regs
   import chm_router_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctrl_we,
   input  logic [CTRL_W-1:0] ctrl_wdata,
   input  logic              mode_we,
   input  logic [MODE_W-1:0] mode_wdata,
   output logic [CTRL_W-1:0] ctrl_q,
   output logic [MODE_W-1:0] mode_q,
   output chan_mode_e        chan_mode,
   output logic              rx_path_en,
   output logic              tx_path_en,
   output logic              rx_flush,
   output logic              tx_flush
);

   localparam logic [CTRL_W-1:0] SELF_CLR_MASK =
      ~((CTRL_W'(1) << CB_RX_FLUSH) | (CTRL_W'(1) << CB_TX_FLUSH));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= CTRL_RST;
      end else if (ctrl_we) begin
         ctrl_q <= ctrl_wdata & SELF_CLR_MASK;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= MODE_RST;
      end else if (mode_we) begin
         mode_q <= mode_wdata;
      end
   end

   always_comb begin
      chan_mode  = chan_mode_e'(mode_q[MODE_LSB +: 2]);
      rx_path_en = ctrl_q[CB_RX_EN] & ~ctrl_q[CB_RX_DIS];
      tx_path_en = ctrl_q[CB_TX_EN] & ~ctrl_q[CB_TX_DIS];
      rx_flush   = ctrl_we & ctrl_wdata[CB_RX_FLUSH];
      tx_flush   = ctrl_we & ctrl_wdata[CB_TX_FLUSH];
   end

endmodule

// File: rtl/chm_route_decode.sv
module chm_route_decode
   import chm_router_pkg::*;
(
   input  chan_mode_e chan_mode,
   output route_t     route
);

   always_comb begin
      route = '0;
      unique case (chan_mode)
         CHM_NORMAL: begin
            route.host_tx = 1'b1;
            route.line_rx = 1'b1;
         end
         CHM_ECHO: begin
            route.line_rx = 1'b1;
            route.line_tx = 1'b1;
         end
         CHM_LOCAL_LB: begin
            route.host_rx = 1'b1;
         end
         CHM_REMOTE_LB: begin
            route.line_tx = 1'b1;
         end
         default: route = '0;
      endcase
   end

endmodule

// File: rtl/chm_fifo_gate.sv
module chm_fifo_gate #(
   parameter int DEPTH  = 64,
   parameter int DATA_W = 8,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              path_en,
   input  logic [CNT_W-1:0]  count,
   input  logic              host_req,
   input  logic [DATA_W-1:0] host_data,
   input  logic              line_req,
   input  logic [DATA_W-1:0] line_data,
   output logic              has_space,
   output logic              push,
   output logic [DATA_W-1:0] push_data,
   output logic              drop_full
);

   localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

   logic req;

   always_comb begin
      has_space = (count < FULL_CNT);
      req       = host_req | line_req;
      push_data = host_req ? host_data : line_data;
      push      = path_en & req & has_space;
      drop_full = path_en & req & ~has_space;
   end

endmodule

// File: rtl/chm_rx_reader.sv
module chm_rx_reader #(
   parameter int DEPTH  = 64,
   parameter int DATA_W = 8,
   localparam int CNT_W = $clog2(DEPTH + 1),
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic              path_en,
   input  logic              host_rd,
   input  logic [CNT_W-1:0]  count,
   input  logic [AW-1:0]     wptr,
   input  logic [DATA_W-1:0] rd_data,
   output logic [AW-1:0]     rd_addr,
   output logic              pop,
   output logic [DATA_W-1:0] rdata
);

   localparam bit POW2 = ((DEPTH & (DEPTH - 1)) == 0);

   generate
      if (POW2) begin : g_pow2
         always_comb rd_addr = wptr - count[AW-1:0];
      end else begin : g_mod
         localparam int SW = CNT_W + 1;
         logic [SW-1:0] sum;
         always_comb begin
            sum = SW'(wptr) + SW'(DEPTH) - SW'(count);
            if (sum >= SW'(DEPTH)) begin
               sum = sum - SW'(DEPTH);
            end
            rd_addr = sum[AW-1:0];
         end
      end
   endgenerate

   logic avail;

   always_comb begin
      avail = path_en & (count != '0);
      pop   = host_rd & avail;
      rdata = avail ? rd_data : '0;
   end

endmodule

// File: rtl/chm_router.sv
module chm_router
   import chm_router_pkg::*;
#(
   parameter int DEPTH  = 64,
   parameter int DATA_W = 8,
   localparam int CNT_W = $clog2(DEPTH + 1),
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_ctrl_we,
   input  logic [CTRL_W-1:0] cfg_ctrl_wdata,
   input  logic              cfg_mode_we,
   input  logic [MODE_W-1:0] cfg_mode_wdata,
   output logic [CTRL_W-1:0] ctrl_q,
   output logic [MODE_W-1:0] mode_q,
   input  logic              host_wr,
   input  logic [DATA_W-1:0] host_wdata,
   input  logic              host_rd,
   output logic [DATA_W-1:0] host_rdata,
   input  logic              line_valid,
   input  logic [DATA_W-1:0] line_data,
   output logic              line_ready,
   input  logic [CNT_W-1:0]  rx_count,
   input  logic [CNT_W-1:0]  tx_count,
   input  logic [AW-1:0]     rx_wptr,
   input  logic [DATA_W-1:0] rx_rd_data,
   output logic [AW-1:0]     rx_rd_addr,
   output logic              rx_push,
   output logic [DATA_W-1:0] rx_push_data,
   output logic              tx_push,
   output logic [DATA_W-1:0] tx_push_data,
   output logic              rx_pop,
   output logic              rx_flush,
   output logic              tx_flush,
   output logic              rx_overrun
);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("chm_router: DEPTH must be at least 2");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("chm_router: DATA_W must be at least 1");
      end
   endgenerate

   chan_mode_e chan_mode;
   route_t     route;
   logic       rx_path_en;
   logic       tx_path_en;

   chm_cfg_regs u_cfg (
      .clk        (clk),
      .rst_n      (rst_n),
      .ctrl_we    (cfg_ctrl_we),
      .ctrl_wdata (cfg_ctrl_wdata),
      .mode_we    (cfg_mode_we),
      .mode_wdata (cfg_mode_wdata),
      .ctrl_q     (ctrl_q),
      .mode_q     (mode_q),
      .chan_mode  (chan_mode),
      .rx_path_en (rx_path_en),
      .tx_path_en (tx_path_en),
      .rx_flush   (rx_flush),
      .tx_flush   (tx_flush)
   );

   chm_route_decode u_dec (
      .chan_mode (chan_mode),
      .route     (route)
   );

   logic [NPATH-1:0]             p_en;
   logic [NPATH-1:0][CNT_W-1:0]  p_count;
   logic [NPATH-1:0]             p_host_req;
   logic [NPATH-1:0]             p_line_req;
   logic [NPATH-1:0]             p_space;
   logic [NPATH-1:0]             p_push;
   logic [NPATH-1:0][DATA_W-1:0] p_data;
   logic [NPATH-1:0]             p_drop;
   logic [NPATH-1:0]             p_line_tgt;

   always_comb begin
      p_en[PATH_RX]       = rx_path_en;
      p_en[PATH_TX]       = tx_path_en;
      p_count[PATH_RX]    = rx_count;
      p_count[PATH_TX]    = tx_count;
      p_host_req[PATH_RX] = host_wr & route.host_rx;
      p_host_req[PATH_TX] = host_wr & route.host_tx;
      p_line_tgt[PATH_RX] = route.line_rx;
      p_line_tgt[PATH_TX] = route.line_tx;
      p_line_req          = {NPATH{line_valid}} & p_line_tgt;
   end

   generate
      for (genvar p = 0; p < NPATH; p++) begin : g_path
         chm_fifo_gate #(
            .DEPTH  (DEPTH),
            .DATA_W (DATA_W)
         ) u_gate (
            .path_en   (p_en[p]),
            .count     (p_count[p]),
            .host_req  (p_host_req[p]),
            .host_data (host_wdata),
            .line_req  (p_line_req[p]),
            .line_data (line_data),
            .has_space (p_space[p]),
            .push      (p_push[p]),
            .push_data (p_data[p]),
            .drop_full (p_drop[p])
         );
      end
   endgenerate

   always_comb begin
      rx_push      = p_push[PATH_RX];
      rx_push_data = p_data[PATH_RX];
      tx_push      = p_push[PATH_TX];
      tx_push_data = p_data[PATH_TX];
      line_ready   = &(~p_line_tgt | p_space);
   end

   chm_rx_reader #(
      .DEPTH  (DEPTH),
      .DATA_W (DATA_W)
   ) u_rd (
      .path_en (rx_path_en),
      .host_rd (host_rd),
      .count   (rx_count),
      .wptr    (rx_wptr),
      .rd_data (rx_rd_data),
      .rd_addr (rx_rd_addr),
      .pop     (rx_pop),
      .rdata   (host_rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_overrun <= 1'b0;
      end else begin
         rx_overrun <= |p_drop;
      end
   end

endmodule

// File: rtl/chm_router_chk.sv
module chm_router_chk
   import chm_router_pkg::*;
#(
   parameter int DEPTH  = 64,
   parameter int DATA_W = 8,
   localparam int CNT_W = $clog2(DEPTH + 1),
   localparam int AW    = $clog2(DEPTH)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_ctrl_we,
   input logic [CTRL_W-1:0] cfg_ctrl_wdata,
   input logic [CTRL_W-1:0] ctrl_q,
   input logic [MODE_W-1:0] mode_q,
   input logic              host_wr,
   input logic              line_valid,
   input logic              line_ready,
   input logic [CNT_W-1:0]  rx_count,
   input logic [CNT_W-1:0]  tx_count,
   input logic              rx_push,
   input logic              tx_push,
   input logic              rx_pop,
   input logic              rx_overrun
);

   localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

   logic [1:0] md;
   assign md = mode_q[MODE_LSB +: 2];

   // R5
   p_rx_no_push_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rx_push |-> (rx_count < FULL_CNT));
   p_tx_no_push_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
      tx_push |-> (tx_count < FULL_CNT));
   p_overrun_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rx_overrun |-> $past(line_valid || host_wr));

   // R2
   p_host_dropped_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && !line_valid && md[0]) |-> (!rx_push && !tx_push));

   // R3
   p_local_line_dropped_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (line_valid && !host_wr && md == 2'd2) |-> (!rx_push && !tx_push));

   // R4
   p_rx_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_q[CB_RX_EN] || ctrl_q[CB_RX_DIS]) |-> (!rx_push && !rx_pop));
   p_tx_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_q[CB_TX_EN] || ctrl_q[CB_TX_DIS]) |-> !tx_push);

   // R6
   p_pop_nonempty_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rx_pop |-> (rx_count != '0));

   // R8
   p_ready_normal_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (line_ready && md == 2'd0) |-> (rx_count < FULL_CNT));

   // R9
   p_ctrl_selfclr_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_ctrl_we |=> (ctrl_q == {$past(cfg_ctrl_wdata[CTRL_W-1:2]), 2'b00}));

endmodule

bind chm_router chm_router_chk #(
   .DEPTH  (DEPTH),
   .DATA_W (DATA_W)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .cfg_ctrl_we    (cfg_ctrl_we),
   .cfg_ctrl_wdata (cfg_ctrl_wdata),
   .ctrl_q         (ctrl_q),
   .mode_q         (mode_q),
   .host_wr        (host_wr),
   .line_valid     (line_valid),
   .line_ready     (line_ready),
   .rx_count       (rx_count),
   .tx_count       (tx_count),
   .rx_push        (rx_push),
   .tx_push        (tx_push),
   .rx_pop         (rx_pop),
   .rx_overrun     (rx_overrun)
);

// File: tb/tb_chm_router.sv
module tb_chm_router;

   localparam int DEPTH  = 64;
   localparam int DATA_W = 8;
   localparam int CNT_W  = $clog2(DEPTH + 1);
   localparam int AW     = $clog2(DEPTH);

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cfg_ctrl_we = 1'b0;
   logic [8:0]        cfg_ctrl_wdata = '0;
   logic              cfg_mode_we = 1'b0;
   logic [9:0]        cfg_mode_wdata = '0;
   logic [8:0]        ctrl_q;
   logic [9:0]        mode_q;
   logic              host_wr = 1'b0;
   logic [DATA_W-1:0] host_wdata = '0;
   logic              host_rd = 1'b0;
   logic [DATA_W-1:0] host_rdata;
   logic              line_valid = 1'b0;
   logic [DATA_W-1:0] line_data = '0;
   logic              line_ready;
   logic [CNT_W-1:0]  rx_count = '0;
   logic [CNT_W-1:0]  tx_count = '0;
   logic [AW-1:0]     rx_wptr = '0;
   logic [DATA_W-1:0] rx_rd_data = '0;
   logic [AW-1:0]     rx_rd_addr;
   logic              rx_push;
   logic [DATA_W-1:0] rx_push_data;
   logic              tx_push;
   logic [DATA_W-1:0] tx_push_data;
   logic              rx_pop;
   logic              rx_flush;
   logic              tx_flush;
   logic              rx_overrun;

   always #5 clk = ~clk;

   chm_router #(.DEPTH(DEPTH), .DATA_W(DATA_W)) dut (
      .clk(clk), .rst_n(rst_n),
      .cfg_ctrl_we(cfg_ctrl_we), .cfg_ctrl_wdata(cfg_ctrl_wdata),
      .cfg_mode_we(cfg_mode_we), .cfg_mode_wdata(cfg_mode_wdata),
      .ctrl_q(ctrl_q), .mode_q(mode_q),
      .host_wr(host_wr), .host_wdata(host_wdata),
      .host_rd(host_rd), .host_rdata(host_rdata),
      .line_valid(line_valid), .line_data(line_data), .line_ready(line_ready),
      .rx_count(rx_count), .tx_count(tx_count), .rx_wptr(rx_wptr),
      .rx_rd_data(rx_rd_data), .rx_rd_addr(rx_rd_addr),
      .rx_push(rx_push), .rx_push_data(rx_push_data),
      .tx_push(tx_push), .tx_push_data(tx_push_data),
      .rx_pop(rx_pop), .rx_flush(rx_flush), .tx_flush(tx_flush),
      .rx_overrun(rx_overrun)
   );

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   typedef struct {
      bit                to_tx;
      logic [DATA_W-1:0] d;
      string             tag;
   } exp_t;

   exp_t exp_q[$];

   task automatic chk(input bit ok, input string tag,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // Scoreboard monitor: every push seen must match the head of the queue.
   initial begin
      forever begin
         @(negedge clk);
         #4;
         if (rst_n && rx_push) begin
            if (exp_q.size() == 0 || exp_q[0].to_tx) begin
               chk(1'b0, "unexpected RX push (R2/R3/R4/R5)", {24'h0, rx_push_data}, 32'hFFFF);
            end else begin
               chk(rx_push_data == exp_q[0].d, exp_q[0].tag, {24'h0, rx_push_data}, {24'h0, exp_q[0].d});
               void'(exp_q.pop_front());
            end
         end
         if (rst_n && tx_push) begin
            if (exp_q.size() == 0 || !exp_q[0].to_tx) begin
               chk(1'b0, "unexpected TX push (R2/R3/R4/R5)", {24'h0, tx_push_data}, 32'hFFFF);
            end else begin
               chk(tx_push_data == exp_q[0].d, exp_q[0].tag, {24'h0, tx_push_data}, {24'h0, exp_q[0].d});
               void'(exp_q.pop_front());
            end
         end
      end
   end

   task automatic expect_push(input bit to_tx, input logic [DATA_W-1:0] d, input string tag);
      exp_t e;
      e.to_tx = to_tx;
      e.d     = d;
      e.tag   = tag;
      exp_q.push_back(e);
   endtask

   task automatic write_ctrl(input logic [8:0] v);
      @(negedge clk);
      cfg_ctrl_we    = 1'b1;
      cfg_ctrl_wdata = v;
      @(negedge clk);
      cfg_ctrl_we    = 1'b0;
   endtask

   task automatic write_mode(input logic [9:0] v);
      @(negedge clk);
      cfg_mode_we    = 1'b1;
      cfg_mode_wdata = v;
      @(negedge clk);
      cfg_mode_we    = 1'b0;
   endtask

   task automatic host_write(input logic [7:0] d, input bit to_rx, input bit to_tx, input string tag);
      @(negedge clk);
      host_wr    = 1'b1;
      host_wdata = d;
      if (to_rx) expect_push(1'b0, d, tag);
      if (to_tx) expect_push(1'b1, d, tag);
      #6;
      chk(exp_q.size() == 0, tag, exp_q.size(), 0);
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic line_byte(input logic [7:0] d, input bit to_rx, input bit to_tx, input string tag);
      @(negedge clk);
      line_valid = 1'b1;
      line_data  = d;
      if (to_rx) expect_push(1'b0, d, tag);
      if (to_tx) expect_push(1'b1, d, tag);
      #6;
      chk(exp_q.size() == 0, tag, exp_q.size(), 0);
      @(negedge clk);
      line_valid = 1'b0;
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #4;
      // R10 / R1 reset state
      chk(ctrl_q == 9'h128, "R10 control reset", ctrl_q, 9'h128);
      chk(mode_q == 10'h0, "R1 mode reset", mode_q, 0);
      chk(rx_overrun == 1'b0, "R5 overrun idle after reset", rx_overrun, 0);
      chk(line_ready == 1'b1, "R8 ready after reset", line_ready, 1);

      // R4: both paths disabled at reset, host write dropped
      host_write(8'hA5, 1'b0, 1'b0, "R4 tx gated at reset");

      // R9: flush both, stored bits 1:0 read 0
      @(negedge clk);
      cfg_ctrl_we = 1'b1;
      cfg_ctrl_wdata = 9'h017;
      #4;
      chk(rx_flush && tx_flush, "R9 both flush pulses", {rx_flush, tx_flush}, 2'b11);
      @(negedge clk);
      cfg_ctrl_we = 1'b0;
      #4;
      chk(ctrl_q == 9'h014, "R9 self-clear stored", ctrl_q, 9'h014);
      chk(!rx_flush && !tx_flush, "R9 flush is a pulse", {rx_flush, tx_flush}, 0);
      @(negedge clk);
      cfg_ctrl_we = 1'b1;
      cfg_ctrl_wdata = 9'h015;
      #4;
      chk(rx_flush && !tx_flush, "R9 rx flush only", {rx_flush, tx_flush}, 2'b10);
      @(negedge clk);
      cfg_ctrl_we = 1'b0;

      // Normal mode routing (R2, R3)
      host_write(8'hA5, 1'b0, 1'b1, "R2 normal host to TX");
      line_byte(8'h3C, 1'b1, 1'b0, "R3 normal line to RX");

      // Host reads (R6, R7)
      @(negedge clk);
      host_rd = 1'b1;
      rx_count = '0;
      rx_rd_data = 8'h9E;
      #4;
      chk(host_rdata == 8'h00 && !rx_pop, "R6 empty read returns 0", {rx_pop, host_rdata}, 0);
      @(negedge clk);
      rx_count = 7'd5;
      rx_wptr = 6'd2;
      #4;
      chk(host_rdata == 8'h9E && rx_pop, "R6 read pops and returns data", {rx_pop, host_rdata}, {1'b1, 8'h9E});
      chk(rx_rd_addr == 6'd61, "R7 wrapped read address", rx_rd_addr, 61);
      @(negedge clk);
      rx_count = 7'd3;
      rx_wptr = 6'd10;
      #4;
      chk(rx_rd_addr == 6'd7, "R7 plain read address", rx_rd_addr, 7);
      @(negedge clk);
      host_rd = 1'b0;
      rx_count = 7'd64;
      #4;
      chk(line_ready == 1'b0, "R8 normal RX full not ready", line_ready, 0);

      // R5: full drop and one-cycle overrun
      line_byte(8'h55, 1'b0, 1'b0, "R5 byte dropped when RX full");
      #4;
      chk(rx_overrun == 1'b1, "R5 overrun raised", rx_overrun, 1);
      @(negedge clk);
      #4;
      chk(rx_overrun == 1'b0, "R5 overrun one cycle", rx_overrun, 0);
      rx_count = '0;

      // Echo mode (R1, R2, R3, R8)
      write_mode(10'h100);
      #4;
      chk(mode_q == 10'h100, "R1 mode stored", mode_q, 10'h100);
      line_byte(8'h77, 1'b1, 1'b1, "R3 echo line to both");
      host_write(8'h99, 1'b0, 1'b0, "R2 echo host dropped");
      @(negedge clk);
      tx_count = 7'd64;
      #4;
      chk(line_ready == 1'b0, "R8 echo TX full not ready", line_ready, 0);
      line_byte(8'h88, 1'b1, 1'b0, "R5 echo TX full, RX still pushed");
      #4;
      chk(rx_overrun == 1'b1, "R5 overrun on TX drop", rx_overrun, 1);

      // Local loopback with unrelated low bits (R1, R2, R3, R8)
      write_mode(10'h2C5);
      #4;
      chk(mode_q == 10'h2C5, "R1 full mode word stored", mode_q, 10'h2C5);
      rx_count = 7'd64;
      #1;
      chk(line_ready == 1'b1, "R8 local loopback always ready", line_ready, 1);
      rx_count = '0;
      tx_count = '0;
      host_write(8'h11, 1'b1, 1'b0, "R2 local host to RX");
      line_byte(8'h22, 1'b0, 1'b0, "R3 local line discarded");

      // Remote loopback (R2, R3, R8)
      write_mode(10'h300);
      line_byte(8'h42, 1'b0, 1'b1, "R3 remote line to TX");
      host_write(8'h33, 1'b0, 1'b0, "R2 remote host dropped");
      @(negedge clk);
      rx_count = 7'd64;
      #4;
      chk(line_ready == 1'b1, "R8 remote ignores RX full", line_ready, 1);

      // RX disabled by disable bit (R4)
      write_mode(10'h000);
      write_ctrl(9'h01C);
      line_byte(8'h66, 1'b0, 1'b0, "R4 RX gated, byte dropped");
      #4;
      chk(rx_overrun == 1'b0, "R4 no overrun on gated path", rx_overrun, 0);
      @(negedge clk);
      host_rd = 1'b1;
      rx_count = 7'd5;
      rx_rd_data = 8'h5A;
      #4;
      chk(!rx_pop && host_rdata == 8'h00, "R4 gated read no pop", {rx_pop, host_rdata}, 0);
      @(negedge clk);
      host_rd = 1'b0;
      host_write(8'h44, 1'b0, 1'b1, "R4 TX still enabled");

      repeat (2) @(negedge clk);
      chk(exp_q.size() == 0, "scoreboard drained (R2/R3)", exp_q.size(), 0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule